// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This unit performs the 16-bit arithmetic of a small 8-bit processor core. It can step a register pair up or down by one, add a register pair to HL, and add a signed byte displacement to the stack pointer. The displaced sum is sent back to SP or into HL. It also produces the updated zero, subtract, half-carry and carry flags, which each operation treats in its own way.

The unit is a single pipeline stage. The surrounding sequencer drives an operation code, a pair selector, the current values of HL, BC, DE and SP, a displacement byte and the current flags. The combinational result is captured on the next rising clock edge. From then on, the registered outputs give the 16-bit result, a write-back enable, the code of the pair that should receive the result, and the new flags. There is one state register. It is RESET while `rst_n` is low, with all outputs zero. From the first rising edge with `rst_n` high it is RUN, and it loads a new result on every edge. RESET moves to RUN when reset is released. RUN moves back to RESET when reset is asserted.

Operation codes: 000 idle, 001 pair increment, 010 pair decrement, 011 add pair to HL, 100 add displacement to SP, 101 SP plus displacement into HL. Codes 110 and 111 are also idle. The flag vector packs Z in bit 3, N in bit 2, H in bit 1 and C in bit 0.

Top module: `aau_top`

## Requirements
- R1: The pair selector maps 00 to BC, 01 to DE, 10 to HL and 11 to SP. For increment, decrement and add-to-HL, the selected pair is the operand.
- R2: Increment (001) gives the operand plus one, modulo 2^16 (0xFFFF wraps to 0x0000). The write-back target is the selected pair code.
- R3: Decrement (010) gives the operand minus one, modulo 2^16 (0x0000 wraps to 0xFFFF). The write-back target is the selected pair code.
- R4: Add-to-HL (011) gives HL plus the operand, modulo 2^16, with target code 10. Z keeps its input value and N is 0. H is the carry out of bit 11 and C is the carry out of bit 15.
- R5: Displacement add (100) gives SP plus the sign-extended displacement byte (range -128 to +127), modulo 2^16, with target code 11. Z and N are 0. H and C are the carries out of bits 3 and 7 of the unsigned sum of SP[7:0] and the displacement byte.
- R6: SP-plus-displacement-into-HL (101) computes the same sum and flags as R5, but with target code 10. SP is not named as a target.
- R7: Increment and decrement pass all four input flags through unchanged.
- R8: Idle codes (000, 110, 111) give write-back enable 0, target code 00, result 0 and flags equal to the input flags.
- R9: Outputs show the result of the inputs present at the previous rising edge. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code |
| pair_sel | input | 2 | Register pair selector |
| hl_in | input | 16 | Current HL value |
| bc_in | input | 16 | Current BC value |
| de_in | input | 16 | Current DE value |
| sp_in | input | 16 | Current SP value |
| disp_in | input | 8 | Signed displacement byte |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result_q | output | 16 | Registered 16-bit result |
| wb_en_q | output | 1 | Registered write-back enable |
| wb_pair_q | output | 2 | Registered target pair code |
| flags_q | output | 4 | Registered new flags {Z,N,H,C} |

## Verification
The assertions compare each registered output with the operation code and input flags from one edge earlier. They assume the inputs are stable across each rising edge, and they stay disarmed until a full clock has passed after reset. The bench changes inputs only on falling edges and holds them for a whole period, so every sampled edge sees settled values. The stimulus covers every operation code with random operands and every pair selector. Directed cases add wrap-around at 0xFFFF and 0x0000, carries out of bits 3, 7, 11 and 15, and negative displacements.

// File: rtl/aau_pkg.sv
package aau_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int FLAG_W = 4;
    localparam int HALF_W = ADDR_W - NIB_W;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'b000,
        OP_INC   = 3'b001,
        OP_DEC   = 3'b010,
        OP_ADDHL = 3'b011,
        OP_ADDSP = 3'b100,
        OP_SPHL  = 3'b101
    } op_e;

    typedef enum logic [1:0] {
        PR_BC = 2'b00,
        PR_DE = 2'b01,
        PR_HL = 2'b10,
        PR_SP = 2'b11
    } pair_e;

    typedef enum logic {
        ST_RESET = 1'b0,
        ST_RUN   = 1'b1
    } state_e;

    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;
endpackage

// File: rtl/aau_pair_mux.sv
module aau_pair_mux
    import aau_pkg::*;
(
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] bc,
    input  logic [ADDR_W-1:0] de,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] operand
);
    always_comb begin
        unique case (sel)
            PR_BC:   operand = bc;
            PR_DE:   operand = de;
            PR_HL:   operand = hl;
            default: operand = sp;
        endcase
    end
endmodule

// File: rtl/aau_calc.sv
module aau_calc
    import aau_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] sp,
    input  logic [BYTE_W-1:0] disp,
    input  logic [FLAG_W-1:0] fin,
    output logic [ADDR_W-1:0] result,
    output logic              wb_en,
    output logic [1:0]        wb_pair,
    output logic [FLAG_W-1:0] fout
);
    logic [ADDR_W-1:0] disp_sx;
    logic [ADDR_W:0]   sum_hl;
    logic [HALF_W:0]   sum_hl_lo;
    logic [BYTE_W:0]   sum_b;
    logic [NIB_W:0]    sum_n;
    logic [ADDR_W-1:0] sum_sp;

    always_comb begin
        disp_sx   = {{(ADDR_W-BYTE_W){disp[BYTE_W-1]}}, disp};
        sum_hl    = {1'b0, hl} + {1'b0, operand};
        sum_hl_lo = {1'b0, hl[HALF_W-1:0]} + {1'b0, operand[HALF_W-1:0]};
        sum_b     = {1'b0, sp[BYTE_W-1:0]} + {1'b0, disp};
        sum_n     = {1'b0, sp[NIB_W-1:0]} + {1'b0, disp[NIB_W-1:0]};
        sum_sp    = sp + disp_sx;
    end

    always_comb begin
        result  = '0;
        wb_en   = 1'b0;
        wb_pair = PR_BC;
        fout    = fin;
        case (op)
            OP_INC: begin
                result  = operand + 1'b1;
                wb_en   = 1'b1;
                wb_pair = sel;
            end
            OP_DEC: begin
                result  = operand - 1'b1;
                wb_en   = 1'b1;
                wb_pair = sel;
            end
            OP_ADDHL: begin
                result   = sum_hl[ADDR_W-1:0];
                wb_en    = 1'b1;
                wb_pair  = PR_HL;
                fout[FN] = 1'b0;
                fout[FH] = sum_hl_lo[HALF_W];
                fout[FC] = sum_hl[ADDR_W];
            end
            OP_ADDSP, OP_SPHL: begin
                result   = sum_sp;
                wb_en    = 1'b1;
                wb_pair  = (op == OP_SPHL) ? PR_HL : PR_SP;
                fout     = {1'b0, 1'b0, sum_n[NIB_W], sum_b[BYTE_W]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/aau_top.sv
module aau_top
    import aau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        pair_sel,
    input  logic [15:0]       hl_in,
    input  logic [15:0]       bc_in,
    input  logic [15:0]       de_in,
    input  logic [15:0]       sp_in,
    input  logic [7:0]        disp_in,
    input  logic [3:0]        flags_in,
    output logic [15:0]       result_q,
    output logic              wb_en_q,
    output logic [1:0]        wb_pair_q,
    output logic [3:0]        flags_q
);
    state_e            state_q;
    logic [ADDR_W-1:0] operand;
    logic [ADDR_W-1:0] res_d;
    logic              wb_en_d;
    logic [1:0]        wb_pair_d;
    logic [FLAG_W-1:0] flags_d;

    aau_pair_mux u_mux (
        .sel     (pair_sel),
        .bc      (bc_in),
        .de      (de_in),
        .hl      (hl_in),
        .sp      (sp_in),
        .operand (operand)
    );

    aau_calc u_calc (
        .op      (op_sel),
        .sel     (pair_sel),
        .operand (operand),
        .hl      (hl_in),
        .sp      (sp_in),
        .disp    (disp_in),
        .fin     (flags_in),
        .result  (res_d),
        .wb_en   (wb_en_d),
        .wb_pair (wb_pair_d),
        .fout    (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q  <= '0;
            wb_en_q   <= 1'b0;
            wb_pair_q <= '0;
            flags_q   <= '0;
        end else begin
            result_q  <= res_d;
            wb_en_q   <= wb_en_d;
            wb_pair_q <= wb_pair_d;
            flags_q   <= flags_d;
        end
    end

    // R7
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC))
        |-> (flags_q == $past(flags_in)));

    // R4
    addhl_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(op_sel) == OP_ADDHL)
        |-> (!flags_q[FN] && flags_q[FZ] == $past(flags_in[FZ]) && wb_pair_q == PR_HL));

    // R5
    disp_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ($past(op_sel) == OP_ADDSP || $past(op_sel) == OP_SPHL))
        |-> (flags_q[FZ] == 1'b0 && flags_q[FN] == 1'b0 && wb_en_q));

    // R6
    sphl_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(op_sel) == OP_SPHL)
        |-> (wb_pair_q == PR_HL && result_q == $past(sp_in) + {{8{$past(disp_in[7])}}, $past(disp_in)}));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ($past(op_sel) == 3'b000 || $past(op_sel) == 3'b110 || $past(op_sel) == 3'b111))
        |-> (!wb_en_q && result_q == '0 && flags_q == $past(flags_in)));
endmodule

// File: tb/aau_top_tb.sv
module aau_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  pair_sel = '0;
    logic [15:0] hl_in = '0, bc_in = '0, de_in = '0, sp_in = '0;
    logic [7:0]  disp_in = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] result_q;
    logic        wb_en_q;
    logic [1:0]  wb_pair_q;
    logic [3:0]  flags_q;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    aau_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .pair_sel(pair_sel),
        .hl_in(hl_in), .bc_in(bc_in), .de_in(de_in), .sp_in(sp_in),
        .disp_in(disp_in), .flags_in(flags_in), .result_q(result_q),
        .wb_en_q(wb_en_q), .wb_pair_q(wb_pair_q), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got res=%h en=%b pr=%0d fl=%b, want res=%h en=%b pr=%0d fl=%b",
                     tag, act[22:7], act[6], act[5:4], act[3:0],
                     exp[22:7], exp[6], exp[5:4], exp[3:0]);
        end
    endtask

    task automatic step(input int op, input int sel, input int hl, input int bc,
                        input int de, input int sp, input int d, input int fl, input string tag);
        int opnd, res, en, pr, z, n, h, c, sd;
        op_sel = op[2:0]; pair_sel = sel[1:0];
        hl_in = hl[15:0]; bc_in = bc[15:0]; de_in = de[15:0]; sp_in = sp[15:0];
        disp_in = d[7:0]; flags_in = fl[3:0];
        opnd = (sel == 0) ? (bc & 'hFFFF) : (sel == 1) ? (de & 'hFFFF) :
               (sel == 2) ? (hl & 'hFFFF) : (sp & 'hFFFF);
        sd = ((d & 'hFF) >= 128) ? (d & 'hFF) - 256 : (d & 'hFF);
        z = (fl >> 3) & 1; n = (fl >> 2) & 1; h = (fl >> 1) & 1; c = fl & 1;
        res = 0; en = 0; pr = 0;
        case (op)
            1: begin res = (opnd + 1) & 'hFFFF; en = 1; pr = sel; end
            2: begin res = (opnd + 65535) & 'hFFFF; en = 1; pr = sel; end
            3: begin
                res = ((hl & 'hFFFF) + opnd) & 'hFFFF; en = 1; pr = 2; n = 0;
                h = (((hl & 'hFFF) + (opnd & 'hFFF)) > 'hFFF) ? 1 : 0;
                c = (((hl & 'hFFFF) + opnd) > 'hFFFF) ? 1 : 0;
            end
            4, 5: begin
                res = ((sp & 'hFFFF) + sd + 65536) & 'hFFFF; en = 1;
                pr = (op == 5) ? 2 : 3; z = 0; n = 0;
                h = (((sp & 'hF) + (d & 'hF)) > 'hF) ? 1 : 0;
                c = (((sp & 'hFF) + (d & 'hFF)) > 'hFF) ? 1 : 0;
            end
            default: ;
        endcase
        @(negedge clk);
        check(tag, {result_q, wb_en_q, wb_pair_q, flags_q},
              {res[15:0], en[0], pr[1:0], z[0], n[0], h[0], c[0]});
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", {result_q, wb_en_q, wb_pair_q, flags_q}, '0);
        rst_n = 1'b1;
        // R1 each pair selected through increment
        step(1, 0, 'h1111, 'h2222, 'h3333, 'h4444, 0, 'hF, "R1 bc");
        step(1, 1, 'h1111, 'h2222, 'h3333, 'h4444, 0, 'h0, "R1 de");
        step(1, 2, 'h1111, 'h2222, 'h3333, 'h4444, 0, 'h5, "R1 hl");
        step(1, 3, 'h1111, 'h2222, 'h3333, 'h4444, 0, 'hA, "R1 sp");
        step(1, 0, 0, 'hFFFF, 0, 0, 0, 'h9, "R2 wrap");
        step(2, 1, 0, 0, 'h0000, 0, 0, 'h6, "R3 wrap");
        step(2, 3, 0, 0, 0, 'h8000, 0, 'hF, "R7 dec flags");
        step(3, 0, 'h0FFF, 'h0001, 0, 0, 0, 'hC, "R4 h11");
        step(3, 2, 'h8000, 0, 0, 0, 0, 'h0, "R4 c15 hl+hl");
        step(3, 3, 'hFFFF, 0, 0, 'h0001, 0, 'h8, "R4 wrap");
        step(4, 0, 0, 0, 0, 'hFFFF, 'h01, 'hF, "R5 wrap up");
        step(4, 0, 0, 0, 0, 'h0000, 'h80, 'hF, "R5 -128");
        step(4, 0, 0, 0, 0, 'h00F8, 'h7F, 'h0, "R5 +127");
        step(5, 0, 'h1234, 0, 0, 'h0000, 'hFF, 'hF, "R6 wrap down");
        step(5, 0, 0, 0, 0, 'hC00F, 'h01, 'h0, "R6 h3");
        step(0, 2, 'hAAAA, 1, 2, 3, 4, 'hB, "R8 idle0");
        step(6, 1, 'hAAAA, 1, 2, 3, 4, 'h4, "R8 idle6");
        step(7, 3, 'hAAAA, 1, 2, 3, 4, 'h7, "R8 idle7");
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(7);
            step(op, $urandom_range(3), $urandom_range(65535), $urandom_range(65535),
                 $urandom_range(65535), $urandom_range(65535), $urandom_range(255),
                 $urandom_range(15), "R2 R3 R4 R5 R6 R7 R8 random");
        end
        rst_n = 1'b0;
        #1;
        check("R9 async reset", {result_q, wb_en_q, wb_pair_q, flags_q}, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule